// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

The block turns CPU writes into the cartridge ROM address space into four small control registers. From those registers and the current CPU address it builds the physical ROM byte address and the external RAM byte address. The CPU sees ROM as two 16 KB windows. The low window (0x0000–0x3FFF) is normally bank 0. The high window (0x4000–0x7FFF) can be switched. Cartridge RAM appears as a single 8 KB window at 0xA000–0xBFFF. The block drives the RAM chip enable and the RAM write enable, and it raises an open-bus flag when a RAM-window access finds RAM disabled or not fitted. In that case the surrounding logic returns 0xFF.

Two parameters decide how the two-bit secondary bank field joins the primary bank field. `PRI_MASK` masks the primary register, and `SEC_LSB` is the bit position where the secondary bits land. The standard board uses mask 0x1F with the secondary field at bit 5. Multigame collection boards are wired one line lower, with mask 0x0F and the secondary field at bit 4. `ROM_BANK_BITS` and `RAM_BANK_BITS` give the fitted sizes as powers of two, and bank numbers wrap modulo the fitted size.

Register decode uses CPU address bits 14:13 of a write below 0x8000:

| Bits 14:13 | CPU range | Register |
|---|---|---|
| 00 | 0x0000–0x1FFF | RAM gate |
| 01 | 0x2000–0x3FFF | primary bank |
| 10 | 0x4000–0x5FFF | secondary bank |
| 11 | 0x6000–0x7FFF | mode |

The mode register is a two-state machine:

- **MODE_BIG_ROM** (reset state, value 0). The low window is bank 0 and RAM uses bank 0.
- **MODE_BIG_RAM** (value 1). The secondary field also steers the low window and selects the RAM bank.
- **Transition ENTER_BIG_RAM** occurs on a mode write with data bit 0 = 1.
- **Transition ENTER_BIG_ROM** occurs on a mode write with data bit 0 = 0.
- Any other cycle holds the current state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the RAM gate is 0, the secondary bank is 0, the mode is MODE_BIG_ROM and the primary bank is 1. A read at 0x4000 therefore maps to ROM byte 0x4000.
- R2: A write to 0x0000–0x1FFF opens the RAM gate when data[3:0] is 0xA. Any other value closes it.
- R3: A write to 0x2000–0x3FFF loads the primary bank as ((data==0 ? 1 : data) & PRI_MASK). A nonzero byte whose masked bits are zero (for example 0x20 with mask 0x1F, or 0x10 with mask 0x0F) leaves the primary bank at 0.
- R4: A write to 0x4000–0x5FFF loads the secondary bank from data[1:0]. A write to 0x6000–0x7FFF loads the mode from data[0], following the ENTER_BIG_RAM and ENTER_BIG_ROM transitions.
- R5: A CPU address in 0x4000–0x7FFF maps to rom_addr = (((sec << SEC_LSB) | pri) mod 2^ROM_BANK_BITS) × 0x4000 + addr[13:0].
- R6: A CPU address in 0x0000–0x3FFF maps to bank 0 in MODE_BIG_ROM. In MODE_BIG_RAM it maps to bank ((sec << SEC_LSB) mod 2^ROM_BANK_BITS). The offset is addr[13:0].
- R7: For an address in 0xA000–0xBFFF, ram_addr = bank × 0x2000 + addr[12:0]. The bank is sec mod 2^RAM_BANK_BITS in MODE_BIG_RAM and 0 in MODE_BIG_ROM.
- R8: ram_ce is 1 exactly for RAM-window addresses while the gate is open and RAM is fitted (HAS_RAM). ram_we is ram_ce gated by cpu_wr. open_bus is 1 exactly for RAM-window addresses otherwise, so a RAM-window write then reaches no RAM.
- R9: Writes at 0x8000–0xFFFF change none of the four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising edge |
| rom_addr | output | ROM_BANK_BITS+14 | Physical ROM byte address |
| ram_addr | output | RAM_BANK_BITS+13 | Physical RAM byte address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| open_bus | output | 1 | RAM-window access finds no RAM; the read returns 0xFF |

## Verification
The bench drives a standard instance and a collection-wired instance, which has no RAM, in parallel. It sweeps all 256 primary-register write values on both. A design that masked before substituting zero would show bank 1 for bytes such as 0x20 or 0x10, where bank 0 is expected. It also sweeps every secondary/mode pair over primary values at the mask edges. A wrong shift or a missing wrap at 64 banks would place the secondary bits in the wrong ROM address bits, and a mode that failed to gate would leak the secondary field into the low window or the RAM bank. Finally, it sweeps the 256 RAM-gate data values and probes writes above 0x7FFF. A gate decoded on the whole byte, or a decoder that ignored address bit 15, would open RAM or corrupt the banks.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int PRI_W  = 5;
    localparam int SEC_W  = 2;
    localparam int FULL_W = PRI_W + SEC_W;

    typedef enum logic {
        MODE_BIG_ROM = 1'b0,
        MODE_BIG_RAM = 1'b1
    } bank_mode_e;

    typedef enum logic [1:0] {
        REG_RAM_GATE = 2'b00,
        REG_PRI      = 2'b01,
        REG_SEC      = 2'b10,
        REG_MODE     = 2'b11
    } reg_sel_e;

    localparam logic [2:0] RAM_WIN_TAG = 3'b101;
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
#(
    parameter logic [7:0] PRI_MASK = 8'h1F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:13]         cpu_addr_hi,
    input  logic [7:0]           cpu_wdata,
    input  logic                 cpu_wr,
    output logic                 ram_gate,
    output logic [PRI_W-1:0]     pri_bank,
    output logic [SEC_W-1:0]     sec_bank,
    output bank_mode_e           mode
);
    logic       wr_hit;
    reg_sel_e   sel;
    logic [7:0] pri_src;
    logic [PRI_W-1:0] pri_d;
    bank_mode_e mode_next;

    assign wr_hit  = cpu_wr && !cpu_addr_hi[15];
    assign sel     = reg_sel_e'(cpu_addr_hi[14:13]);
    assign pri_src = (cpu_wdata == 8'h00) ? 8'h01 : cpu_wdata;
    assign pri_d   = PRI_W'(pri_src & PRI_MASK);

    // mode state machine: next state
    always_comb begin
        mode_next = mode;
        if (wr_hit && sel == REG_MODE) begin
            unique case (mode)
                MODE_BIG_ROM: if (cpu_wdata[0])  mode_next = MODE_BIG_RAM; // ENTER_BIG_RAM
                MODE_BIG_RAM: if (!cpu_wdata[0]) mode_next = MODE_BIG_ROM; // ENTER_BIG_ROM
            endcase
        end
    end

    // mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_BIG_ROM;
        else        mode <= mode_next;
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_gate <= 1'b0;
            pri_bank <= PRI_W'(1);
            sec_bank <= '0;
        end else if (wr_hit) begin
            unique case (sel)
                REG_RAM_GATE: ram_gate <= (cpu_wdata[3:0] == 4'hA);
                REG_PRI:      pri_bank <= pri_d;
                REG_SEC:      sec_bank <= cpu_wdata[SEC_W-1:0];
                REG_MODE:     ;
            endcase
        end
    end

    p_gate_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr_hi == 3'b000 && cpu_wdata[3:0] == 4'hA) |=> ram_gate);
    p_gate_shut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr_hi == 3'b000 && cpu_wdata[3:0] != 4'hA) |=> !ram_gate);
    p_zero_subst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr_hi == 3'b001 && cpu_wdata == 8'h00)
        |=> pri_bank == (PRI_MASK[PRI_W-1:0] & PRI_W'(1)));
    p_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr_hi == 3'b011) |=> mode == bank_mode_e'($past(cpu_wdata[0])));
    p_high_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr || cpu_addr_hi[15]) |=> $stable({ram_gate, pri_bank, sec_bank, mode}));
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
    import cbc_pkg::*;
#(
    parameter int SEC_LSB       = 5,
    parameter int ROM_BANK_BITS = 6,
    localparam int ROM_AW       = ROM_BANK_BITS + 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [14:0]          cpu_addr,
    input  logic [PRI_W-1:0]     pri_bank,
    input  logic [SEC_W-1:0]     sec_bank,
    input  bank_mode_e           mode,
    output logic [ROM_AW-1:0]    rom_addr
);
    logic [FULL_W-1:0] sec_part;
    logic [FULL_W-1:0] bank_full;

    assign sec_part = FULL_W'(sec_bank) << SEC_LSB;

    always_comb begin
        if (cpu_addr[14]) begin
            bank_full = sec_part | FULL_W'(pri_bank);
        end else begin
            unique case (mode)
                MODE_BIG_ROM: bank_full = '0;
                MODE_BIG_RAM: bank_full = sec_part;
            endcase
        end
    end

    assign rom_addr = {ROM_BANK_BITS'(bank_full), cpu_addr[13:0]};

    p_low_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BIG_ROM && !cpu_addr[14]) |-> rom_addr[ROM_AW-1:14] == '0);
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
    import cbc_pkg::*;
#(
    parameter bit HAS_RAM       = 1'b1,
    parameter int RAM_BANK_BITS = 2,
    localparam int RAM_AW       = RAM_BANK_BITS + 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic                 cpu_wr,
    input  logic                 ram_gate,
    input  logic [SEC_W-1:0]     sec_bank,
    input  bank_mode_e           mode,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 ram_ce,
    output logic                 ram_we,
    output logic                 open_bus
);
    logic             in_win;
    logic             live;
    logic [SEC_W-1:0] bank;

    assign in_win = (cpu_addr[15:13] == RAM_WIN_TAG);
    assign live   = ram_gate && HAS_RAM;

    always_comb begin
        unique case (mode)
            MODE_BIG_ROM: bank = '0;
            MODE_BIG_RAM: bank = sec_bank;
        endcase
    end

    assign ram_addr = {RAM_BANK_BITS'(bank), cpu_addr[12:0]};
    assign ram_ce   = in_win && live;
    assign ram_we   = ram_ce && cpu_wr;
    assign open_bus = in_win && !live;

    p_shut_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_gate |-> (!ram_ce && !ram_we));
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_ce, open_bus}));
    p_ram_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BIG_ROM) |-> ram_addr[RAM_AW-1:13] == '0);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter logic [7:0] PRI_MASK      = 8'h1F,
    parameter int         SEC_LSB       = 5,
    parameter int         ROM_BANK_BITS = 6,
    parameter int         RAM_BANK_BITS = 2,
    parameter bit         HAS_RAM       = 1'b1,
    localparam int        ROM_AW        = ROM_BANK_BITS + 14,
    localparam int        RAM_AW        = RAM_BANK_BITS + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_ce,
    output logic              ram_we,
    output logic              open_bus
);
    logic             ram_gate;
    logic [PRI_W-1:0] pri_bank;
    logic [SEC_W-1:0] sec_bank;
    bank_mode_e       mode;

    cbc_regs #(.PRI_MASK(PRI_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr[15:13]),
        .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .ram_gate(ram_gate),
        .pri_bank(pri_bank), .sec_bank(sec_bank), .mode(mode)
    );

    cbc_rom_map #(.SEC_LSB(SEC_LSB), .ROM_BANK_BITS(ROM_BANK_BITS)) u_rom (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr[14:0]),
        .pri_bank(pri_bank), .sec_bank(sec_bank), .mode(mode),
        .rom_addr(rom_addr)
    );

    cbc_ram_map #(.HAS_RAM(HAS_RAM), .RAM_BANK_BITS(RAM_BANK_BITS)) u_ram (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .ram_gate(ram_gate), .sec_bank(sec_bank), .mode(mode),
        .ram_addr(ram_addr), .ram_ce(ram_ce), .ram_we(ram_we),
        .open_bus(open_bus)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mode == MODE_BIG_ROM && !ram_gate && sec_bank == '0 && pri_bank == PRI_W'(1)));
endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;

    logic [19:0] rom_s, rom_c;
    logic [14:0] ram_s, ram_c;
    logic        ce_s, we_s, ob_s, ce_c, we_c, ob_c;

    int n_chk = 0;
    int n_bad = 0;
    int m_gate = 0, m_pri_s = 1, m_pri_c = 1, m_sec = 0, m_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_ctrl #(.PRI_MASK(8'h1F), .SEC_LSB(5), .ROM_BANK_BITS(6),
                     .RAM_BANK_BITS(2), .HAS_RAM(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_addr(rom_s), .ram_addr(ram_s), .ram_ce(ce_s),
        .ram_we(we_s), .open_bus(ob_s));

    cart_bank_ctrl #(.PRI_MASK(8'h0F), .SEC_LSB(4), .ROM_BANK_BITS(6),
                     .RAM_BANK_BITS(2), .HAS_RAM(1'b0)) dut_col (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .rom_addr(rom_c), .ram_addr(ram_c), .ram_ce(ce_c),
        .ram_we(we_c), .open_bus(ob_c));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, cpu_addr, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rom(input int lsb, input int pri, input logic [15:0] a);
        int bank;
        if (a[14]) bank = ((m_sec << lsb) | pri) & 63;
        else       bank = (m_mode != 0) ? ((m_sec << lsb) & 63) : 0;
        return 32'(bank) * 32'h4000 + 32'(a[13:0]);
    endfunction

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        if (!a[15]) begin
            case (a[14:13])
                2'b00: m_gate = (d[3:0] == 4'hA) ? 1 : 0;
                2'b01: begin
                    m_pri_s = ((d == 0) ? 1 : int'(d)) & 8'h1F;
                    m_pri_c = ((d == 0) ? 1 : int'(d)) & 8'h0F;
                end
                2'b10: m_sec = int'(d[1:0]);
                default: m_mode = int'(d[0]);
            endcase
        end
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
    endtask

    task automatic chk_rom(input string tag, input logic [15:0] a);
        look(a);
        chk({tag, " std"}, 32'(rom_s), exp_rom(5, m_pri_s, a));
        chk({tag, " col"}, 32'(rom_c), exp_rom(4, m_pri_c, a));
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog expired got=%0d exp<=150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        look(16'h4000);
        chk("R1 high window", 32'(rom_s), 32'h4000);
        chk("R1 high window col", 32'(rom_c), 32'h4000);
        look(16'h1234);
        chk("R1 low window", 32'(rom_s), 32'h1234);
        look(16'hA010);
        chk("R1 gate shut ce", 32'(ce_s), 0);
        chk("R1 gate shut ob", 32'(ob_s), 1);
        chk("R1 ram bank0", 32'(ram_s), 32'h0010);

        // R3 / R5 primary sweep over all byte values
        for (int d = 0; d < 256; d++) begin
            do_wr(16'h2000 | 16'((d * 29) & 16'h1FFF), 8'(d));
            chk_rom("R3 R5 primary", 16'h4000 | 16'((d * 53) & 16'h3FFF));
        end
        do_wr(16'h2000, 8'h20);
        chk_rom("R3 masked zero", 16'h4000);
        do_wr(16'h2000, 8'h10);
        chk_rom("R3 masked zero", 16'h7FFF);

        // R4 / R5 / R6 / R7 secondary x mode x primary
        do_wr(16'h0000, 8'h3A);
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 4; k++) begin
                    do_wr(16'h4000 | 16'(s * 97), 8'(s | ((k * 37) & 8'hFC)));
                    do_wr(16'h6000 | 16'(k * 211), 8'(m | 8'h0E));
                    case (k)
                        0: do_wr(16'h3FFF, 8'h01);
                        1: do_wr(16'h2100, 8'h0F);
                        2: do_wr(16'h2200, 8'h10);
                        default: do_wr(16'h2300, 8'h1F);
                    endcase
                    chk_rom("R4 R5 high", 16'h4000 | 16'(k * 1013));
                    chk_rom("R6 low", 16'h0000 | 16'(k * 4001 & 16'h3FFF));
                    look(16'hA000 | 16'(k * 777 & 16'h1FFF));
                    chk("R7 ram addr", 32'(ram_s),
                        32'(((m != 0) ? s : 0) * 32'h2000 + (k * 777 & 32'h1FFF)));
                    chk("R7 ram ce", 32'(ce_s), 1);
                    chk("R8 absent ob", 32'(ob_c), 1);
                end
            end
        end

        // R2 gate sweep
        for (int d = 0; d < 256; d++) begin
            do_wr(16'(((d * 31) & 16'h1FFF)), 8'(d));
            look(16'hA000 | 16'((d * 17) & 16'h1FFF));
            chk("R2 gate ce", 32'(ce_s), 32'(m_gate));
            chk("R8 gate ob", 32'(ob_s), 32'(1 - m_gate));
            chk("R8 absent ce", 32'(ce_c), 0);
        end

        // R8 write probes
        do_wr(16'h0000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'hB123; cpu_wdata = 8'h55; cpu_wr = 1'b1; #1;
        chk("R8 we shut", 32'(we_s), 0);
        chk("R8 we absent", 32'(we_c), 0);
        @(posedge clk); #1 cpu_wr = 1'b0;
        do_wr(16'h1000, 8'hFA);
        @(negedge clk);
        cpu_addr = 16'hB123; cpu_wdata = 8'h55; cpu_wr = 1'b1; #1;
        chk("R8 we open", 32'(we_s), 1);
        chk("R8 we absent open", 32'(we_c), 0);
        look(16'h9000);
        chk("R8 outside ce", 32'(ce_s), 0);
        chk("R8 outside ob", 32'(ob_s), 0);

        // R9 writes above 0x7FFF ignored
        do_wr(16'h4000, 8'h02);
        do_wr(16'h6000, 8'h01);
        do_wr(16'h2000, 8'h05);
        for (int k = 0; k < 32; k++) begin
            do_wr(16'h8000 | 16'(k * 1021), 8'(k * 8));
        end
        chk_rom("R9 high", 16'h4321);
        chk_rom("R9 low", 16'h0321);
        look(16'hA001);
        chk("R9 gate", 32'(ce_s), 1);
        chk("R9 ram bank", 32'(ram_s), 32'h4001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule